// File: doc/BRIEF.md
# Low-Speed USB Line Receiver

This block turns the two wires of a low-speed USB link into bytes. It runs from a clock eight times the 1.5 Mb/s bit rate. Both lines first pass through a synchroniser. A phase counter then restarts on every line transition and marks the centre of each bit cell. A receiver state machine hunts for the synchronisation pattern and confirms its end when it sees two K bits in a row. After that it NRZI-decodes the line, drops stuffed bits and shifts bytes in least significant bit first.

Each complete byte leaves on a one-cycle strobe. The strobe serves as the write of a receive buffer whose depth is a parameter. When the line shows single-ended zero, the block ends the packet. It reports the number of complete bytes and throws away any partly received byte. A packet longer than the buffer raises an overflow event. After an overflow, the rest of that packet is ignored until the line goes to single-ended zero. If the sync pattern stops without the expected K edge, the block raises a sync-timeout event and goes back to hunting. Checking CRCs and decoding packet identifiers are left to the logic that follows.

Top module: `usb_ls_rx`

## Requirements
- R1: While reset is asserted and in the first cycles after it, all of the following are low or zero: byte_valid_o, pkt_end_o, overflow_o, sync_timeout_o and byte_count_o. The receiver waits in its hunting state with the line idle at J. The line is encoded as {dp_i, dm_i}: J = 01, K = 10, single-ended zero = 00.
- R2: A packet starts only after the synchronised line changes from J to K. Byte reception begins only once two consecutive bit-centre samples both read K. A K followed by a J keeps the receiver in the sync hunt, so the pattern K,J,K,J,K,J,K,K enters byte reception.
- R3: Each received bit is NRZI-decoded. A sample equal to the previous bit's level decodes as 1. A sample that differs decodes as 0. The reference level at the start of data is the final K of the sync pattern.
- R4: After six consecutive decoded 1s, the next bit cell is a stuffed bit and is discarded. The final sync bit counts as the first of these 1s. The run count restarts after the stuffed bit and after every decoded 0.
- R5: Every eighth data bit produces a one-cycle pulse on byte_valid_o. The matching byte appears on byte_o, with the first received bit in bit 0. At most one of byte_valid_o, pkt_end_o, overflow_o and sync_timeout_o is high in any cycle.
- R6: A single-ended-zero sample in the first bit cell of a byte is decoded as an ordinary bit, which absorbs a dribble bit added by a hub. A single-ended-zero sample in any later cell of a byte ends the packet. pkt_end_o then pulses with byte_count_o equal to the number of bytes delivered, and the partial byte is dropped.
- R7: At most BUF_BYTES bytes are delivered per packet. When one more byte completes, overflow_o pulses and that byte is not delivered. The block then ignores the line until it reads single-ended zero, with no pkt_end_o for that packet.
- R8: In the sync hunt, a J sample directly after a J sample, or a single-ended-zero sample, pulses sync_timeout_o. The receiver then returns to hunting for a J-to-K edge, and no byte is delivered.
- R9: Bits are sampled CLKS_PER_BIT/2 clocks after the most recent transition, and the phase restarts on each transition. Bit cells that alternate between one clock shorter and one clock longer than nominal therefore decode correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, CLKS_PER_BIT times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dp_i | input | 1 | D+ line level |
| dm_i | input | 1 | D- line level |
| byte_valid_o | output | 1 | One-cycle strobe for a complete byte |
| byte_o | output | 8 | Received byte, first bit in bit 0 |
| pkt_end_o | output | 1 | One-cycle pulse at end of packet |
| byte_count_o | output | $clog2(BUF_BYTES+1) | Complete bytes in the packet, valid with pkt_end_o |
| overflow_o | output | 1 | One-cycle pulse when a byte arrives beyond BUF_BYTES |
| sync_timeout_o | output | 1 | One-cycle pulse when the sync hunt finds no K edge |

## Verification
The bench keeps CLKS_PER_BIT at eight and reduces BUF_BYTES to four. A six-byte packet therefore reaches the overflow path and the drain that follows it, while short packets stay in range. With eight-clock cells, the bench can also stretch and shrink cells by one clock to exercise phase re-alignment. At this buffer size, the all-ones bytes pass through the stuffing path several times within one packet.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

  // Line state as {dp, dm}
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_SYNC  = 2'd1,
    ST_DATA  = 2'd2,
    ST_DRAIN = 2'd3
  } rx_state_t;

endpackage

// File: rtl/usb_ls_rx_linesync.sv
module usb_ls_rx_linesync
  import usb_ls_rx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dp_i,
  input  logic  dm_i,
  output line_t line_now,
  output line_t line_prev
);

  // STAGES synchroniser pairs plus one pair of history for edge detection
  localparam int W = 2 * (STAGES + 1);

  logic [W-1:0] chain_q;
  logic [W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[W-3:0], dp_i, dm_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {(STAGES + 1){2'b01}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign line_now  = line_t'(chain_q[W-3:W-4]);
  assign line_prev = line_t'(chain_q[W-1:W-2]);

endmodule

// File: rtl/usb_ls_rx_bitclk.sv
module usb_ls_rx_bitclk #(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic realign,
  output logic strobe
);

  localparam int PW = $clog2(CLKS_PER_BIT);
  localparam logic [PW-1:0] LAST   = PW'(CLKS_PER_BIT - 1);
  localparam logic [PW-1:0] CENTRE = PW'(CLKS_PER_BIT / 2);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;

  always_comb begin
    if (realign) begin
      phase_d = PW'(1);
    end else if (phase_q == LAST) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign strobe = (phase_q == CENTRE);

endmodule

// File: rtl/usb_ls_rx_nrzi.sv
module usb_ls_rx_nrzi
  import usb_ls_rx_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  step,
  input  line_t sample,
  output logic  bit_ok,
  output logic  bit_val
);

  localparam int RW = $clog2(STUFF_RUN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(STUFF_RUN);

  line_t         level_q, level_d;
  logic [RW-1:0] ones_q, ones_d;
  logic          stuffed;

  assign stuffed = (ones_q == RUN_MAX);
  assign bit_val = (sample == level_q);
  assign bit_ok  = step && !stuffed;

  always_comb begin
    level_d = level_q;
    ones_d  = ones_q;
    if (restart) begin
      level_d = LN_K;
      ones_d  = RW'(1);
    end else if (step) begin
      level_d = sample;
      if (stuffed || !bit_val) begin
        ones_d = '0;
      end else begin
        ones_d = ones_q + RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LN_K;
      ones_q  <= '0;
    end else begin
      level_q <= level_d;
      ones_q  <= ones_d;
    end
  end

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 8,
  parameter int BUF_BYTES    = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int STUFF_RUN    = 6,
  localparam int CW          = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dp_i,
  input  logic          dm_i,
  output logic          byte_valid_o,
  output logic [7:0]    byte_o,
  output logic          pkt_end_o,
  output logic [CW-1:0] byte_count_o,
  output logic          overflow_o,
  output logic          sync_timeout_o
);

  localparam logic [CW-1:0] CAP = CW'(BUF_BYTES);

  line_t line_now, line_prev;
  logic  line_edge;
  logic  strobe;
  logic  nrzi_restart, nrzi_step, bit_ok, bit_val;
  logic  not_data_level;

  rx_state_t     state_q, state_d;
  logic          sawk_q, sawk_d;
  logic [2:0]    bitpos_q, bitpos_d;
  logic [7:0]    shift_q, shift_d;
  logic [CW-1:0] count_q, count_d;
  logic [7:0]    assembled;

  logic          valid_q, valid_d;
  logic [7:0]    byte_q, byte_d;
  logic          end_q, end_d;
  logic [CW-1:0] total_q, total_d;
  logic          ovf_q, ovf_d;
  logic          tmo_q, tmo_d;

  usb_ls_rx_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .dp_i      (dp_i),
    .dm_i      (dm_i),
    .line_now  (line_now),
    .line_prev (line_prev)
  );

  assign line_edge = (line_now != line_prev);

  usb_ls_rx_bitclk #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_bitclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .realign (line_edge),
    .strobe  (strobe)
  );

  usb_ls_rx_nrzi #(.STUFF_RUN(STUFF_RUN)) u_nrzi (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (nrzi_restart),
    .step    (nrzi_step),
    .sample  (line_now),
    .bit_ok  (bit_ok),
    .bit_val (bit_val)
  );

  assign not_data_level = (line_now == LN_SE0) || (line_now == LN_SE1);
  assign assembled      = {bit_val, shift_q[7:1]};

  always_comb begin
    state_d      = state_q;
    sawk_d       = sawk_q;
    bitpos_d     = bitpos_q;
    shift_d      = shift_q;
    count_d      = count_q;
    valid_d      = 1'b0;
    byte_d       = byte_q;
    end_d        = 1'b0;
    total_d      = total_q;
    ovf_d        = 1'b0;
    tmo_d        = 1'b0;
    nrzi_restart = 1'b0;
    nrzi_step    = 1'b0;

    unique case (state_q)
      ST_HUNT: begin
        if (line_prev == LN_J && line_now == LN_K) begin
          state_d = ST_SYNC;
          sawk_d  = 1'b0;
        end
      end

      ST_SYNC: begin
        if (strobe) begin
          if (line_now == LN_K) begin
            if (sawk_q) begin
              state_d      = ST_DATA;
              nrzi_restart = 1'b1;
              bitpos_d     = '0;
              shift_d      = '0;
              count_d      = '0;
            end else begin
              sawk_d = 1'b1;
            end
          end else if (line_now == LN_J && sawk_q) begin
            sawk_d = 1'b0;
          end else begin
            tmo_d   = 1'b1;
            state_d = ST_HUNT;
          end
        end
      end

      ST_DATA: begin
        if (strobe) begin
          if (not_data_level && bitpos_q != 3'd0) begin
            end_d   = 1'b1;
            total_d = count_q;
            state_d = ST_HUNT;
          end else begin
            nrzi_step = 1'b1;
            if (bit_ok) begin
              shift_d  = assembled;
              bitpos_d = bitpos_q + 3'd1;
              if (bitpos_q == 3'd7) begin
                if (count_q == CAP) begin
                  ovf_d   = 1'b1;
                  state_d = ST_DRAIN;
                end else begin
                  valid_d = 1'b1;
                  byte_d  = assembled;
                  count_d = count_q + CW'(1);
                end
              end
            end
          end
        end
      end

      ST_DRAIN: begin
        if (line_now == LN_SE0) begin
          state_d = ST_HUNT;
        end
      end

      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HUNT;
      sawk_q   <= 1'b0;
      bitpos_q <= '0;
      shift_q  <= '0;
      count_q  <= '0;
      valid_q  <= 1'b0;
      byte_q   <= '0;
      end_q    <= 1'b0;
      total_q  <= '0;
      ovf_q    <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      sawk_q   <= sawk_d;
      bitpos_q <= bitpos_d;
      shift_q  <= shift_d;
      count_q  <= count_d;
      valid_q  <= valid_d;
      byte_q   <= byte_d;
      end_q    <= end_d;
      total_q  <= total_d;
      ovf_q    <= ovf_d;
      tmo_q    <= tmo_d;
    end
  end

  assign byte_valid_o   = valid_q;
  assign byte_o         = byte_q;
  assign pkt_end_o      = end_q;
  assign byte_count_o   = total_q;
  assign overflow_o     = ovf_q;
  assign sync_timeout_o = tmo_q;

endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk #(
  parameter int BUF_BYTES = 8,
  parameter int CW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_valid_o,
  input logic          pkt_end_o,
  input logic [CW-1:0] byte_count_o,
  input logic          overflow_o,
  input logic          sync_timeout_o
);

  // Bytes delivered since the last packet-level event
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (pkt_end_o || overflow_o || sync_timeout_o) begin
      seen_q <= '0;
    end else if (byte_valid_o) begin
      seen_q <= seen_q + CW'(1);
    end
  end

  assert_events_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_valid_o, pkt_end_o, overflow_o, sync_timeout_o}));

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |=> !byte_valid_o);

  assert_count_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end_o |-> (byte_count_o == seen_q));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> (seen_q < CW'(BUF_BYTES)));

  assert_drain_after_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> (!pkt_end_o && !byte_valid_o));

  assert_timeout_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_timeout_o |-> (seen_q == '0));

endmodule

bind usb_ls_rx usb_ls_rx_chk #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .byte_valid_o   (byte_valid_o),
  .pkt_end_o      (pkt_end_o),
  .byte_count_o   (byte_count_o),
  .overflow_o     (overflow_o),
  .sync_timeout_o (sync_timeout_o)
);

// File: tb/tb_usb_ls_rx.sv
`timescale 1ns/1ps
module tb_usb_ls_rx;

  localparam int CPB = 8;
  localparam int BUF = 4;
  localparam int CW  = $clog2(BUF + 1);

  localparam logic [1:0] LV_J   = 2'b01;
  localparam logic [1:0] LV_K   = 2'b10;
  localparam logic [1:0] LV_SE0 = 2'b00;

  // {len[3:0], dribble, jitter, data[47:0]} ; byte i = data[8i +: 8]
  localparam int NVEC = 7;
  localparam logic [53:0] VEC [NVEC] = '{
    {4'd1, 1'b0, 1'b0, 48'h0000_0000_00A5},
    {4'd2, 1'b0, 1'b0, 48'h0000_0000_FF00},
    {4'd3, 1'b1, 1'b0, 48'h0000_0080_7E3F},
    {4'd4, 1'b0, 1'b1, 48'h0000_C301_FFFF},
    {4'd0, 1'b0, 1'b0, 48'h0000_0000_0000},
    {4'd6, 1'b0, 1'b0, 48'h6655_4433_2211},
    {4'd2, 1'b1, 1'b1, 48'h0000_0000_FE5A}
  };

  logic          clk;
  logic          rst_n;
  logic          dp, dm;
  logic          byte_valid;
  logic [7:0]    byte_val;
  logic          pkt_end;
  logic [CW-1:0] byte_count;
  logic          overflow;
  logic          sync_timeout;

  usb_ls_rx #(.CLKS_PER_BIT(CPB), .BUF_BYTES(BUF)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .dp_i           (dp),
    .dm_i           (dm),
    .byte_valid_o   (byte_valid),
    .byte_o         (byte_val),
    .pkt_end_o      (pkt_end),
    .byte_count_o   (byte_count),
    .overflow_o     (overflow),
    .sync_timeout_o (sync_timeout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  // Monitor: record output events away from the active edge
  logic [7:0]    got [256];
  int            got_n = 0;
  int            end_n = 0;
  int            ovf_n = 0;
  int            tmo_n = 0;
  logic [CW-1:0] last_count = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) begin
        if (got_n < 256) got[got_n] = byte_val;
        got_n++;
      end
      if (pkt_end) begin
        end_n++;
        last_count = byte_count;
      end
      if (overflow) ovf_n++;
      if (sync_timeout) tmo_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // Line encoder state
  logic [1:0] lvl;
  int         ones;
  bit         jit;
  bit         jit_ph;

  task automatic hold(input logic [1:0] l);
    int n;
    n = CPB;
    if (jit) begin
      n = jit_ph ? CPB + 1 : CPB - 1;
      jit_ph = ~jit_ph;
    end
    {dp, dm} = l;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] flip(input logic [1:0] l);
    return (l == LV_J) ? LV_K : LV_J;
  endfunction

  task automatic tx_sync();
    hold(LV_K); hold(LV_J); hold(LV_K); hold(LV_J);
    hold(LV_K); hold(LV_J); hold(LV_K); hold(LV_K);
    lvl  = LV_K;
    ones = 1;
  endtask

  task automatic tx_bit(input bit b);
    if (b) begin
      hold(lvl);
      ones++;
      if (ones == 6) begin
        lvl = flip(lvl);
        hold(lvl);
        ones = 0;
      end
    end else begin
      lvl = flip(lvl);
      hold(lvl);
      ones = 0;
    end
  endtask

  task automatic tx_eop(input bit dribble);
    if (dribble) begin
      lvl = flip(lvl);
      hold(lvl);
    end
    hold(LV_SE0);
    hold(LV_SE0);
    repeat (4) hold(LV_J);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int b_got, b_end, b_ovf, b_tmo;
    dp = 1'b0; dm = 1'b1;
    jit = 0; jit_ph = 0; lvl = LV_J; ones = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk({byte_valid, pkt_end, overflow, sync_timeout} == 4'b0 && byte_count == '0,
        "R1 in reset", {byte_valid, pkt_end, overflow, sync_timeout}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk({byte_valid, pkt_end, overflow, sync_timeout} == 4'b0 && byte_count == '0,
        "R1 after reset", {byte_valid, pkt_end, overflow, sync_timeout}, 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      int len, exp_n;
      bit drib, exp_end, exp_ovf;
      logic [47:0] data;
      len  = int'(VEC[v][53:50]);
      drib = VEC[v][49];
      jit  = VEC[v][48];
      data = VEC[v][47:0];
      exp_ovf = (len > BUF);
      exp_end = !exp_ovf;
      exp_n   = exp_ovf ? BUF : len;
      b_got = got_n; b_end = end_n; b_ovf = ovf_n; b_tmo = tmo_n;
      tx_sync();
      for (int i = 0; i < len * 8; i++) tx_bit(data[i]);
      tx_eop(drib);
      jit = 0;
      chk(got_n - b_got == exp_n, jit ? "R5 R9 byte count" : "R5 byte count",
          got_n - b_got, exp_n);
      for (int i = 0; i < exp_n && i < got_n - b_got; i++)
        chk(got[b_got + i] == data[8*i +: 8], "R2 R3 R4 byte value",
            got[b_got + i], data[8*i +: 8]);
      chk(end_n - b_end == int'(exp_end), drib ? "R6 dribble end" : "R6 end pulse",
          end_n - b_end, exp_end);
      if (exp_end)
        chk(int'(last_count) == len, "R6 reported count", last_count, len);
      chk(ovf_n - b_ovf == int'(exp_ovf), "R7 overflow pulse", ovf_n - b_ovf, exp_ovf);
      chk(tmo_n - b_tmo == 0, "R2 no timeout in packet", tmo_n - b_tmo, 0);
    end

    // R6: partial byte dropped at SE0
    b_got = got_n; b_end = end_n;
    tx_sync();
    for (int i = 0; i < 8; i++) tx_bit(i[0]);
    tx_bit(1'b1); tx_bit(1'b0); tx_bit(1'b1);
    tx_eop(1'b0);
    chk(got_n - b_got == 1, "R6 partial bytes", got_n - b_got, 1);
    chk(got[b_got] == 8'hAA, "R3 partial first byte", got[b_got], 8'hAA);
    chk(end_n - b_end == 1 && last_count == CW'(1), "R6 partial count", last_count, 1);

    // R8: K then two J bits -> sync timeout
    b_got = got_n; b_tmo = tmo_n;
    hold(LV_K); hold(LV_J); hold(LV_J); hold(LV_J); hold(LV_J);
    chk(tmo_n - b_tmo == 1, "R8 J after J", tmo_n - b_tmo, 1);
    chk(got_n - b_got == 0, "R8 no bytes", got_n - b_got, 0);

    // R8: SE0 in sync hunt -> sync timeout
    b_tmo = tmo_n; b_end = end_n;
    hold(LV_K); hold(LV_J); hold(LV_SE0); hold(LV_SE0); hold(LV_J); hold(LV_J);
    chk(tmo_n - b_tmo == 1, "R8 SE0 in sync", tmo_n - b_tmo, 1);
    chk(end_n - b_end == 0, "R8 no packet end", end_n - b_end, 0);

    // R2: receiver still works after timeouts
    b_got = got_n;
    tx_sync();
    for (int i = 0; i < 8; i++) tx_bit(i == 0 || i == 7);
    tx_eop(1'b0);
    chk(got_n - b_got == 1 && got[b_got] == 8'h81, "R2 recovery byte", got[b_got], 8'h81);

    finish_run();
  end

endmodule